// File: doc/BRIEF.md
# Single-Bin DFT Correlator

This block measures one frequency component of a sampled response signal. A measurement begins with a start pulse. The block then takes 1024 signed 12-bit samples, all captured while a known excitation tone drives the load. It correlates each sample against an internal reference phasor that turns at the same rate as the excitation, so the result is a single bin of a discrete Fourier transform at that tone. One run of the block produces one point of a frequency sweep.

An internal phase register starts at zero. It advances by `phase_step` for every sample the block accepts. The upper bits of this phase address a quarter-wave sine table, which supplies both the cosine and the sine of the reference. The block adds the products into wide real and imaginary accumulators. When the block is done, it scales both sums down by a fixed right shift, clamps them, and presents them as 16-bit two's-complement words. No window is applied, so every sample has the same weight.

Top module: `dft_bin_correlator`

## Requirements
- R1: After reset, `done` is 0 and both `re_out` and `im_out` read 0.
- R2: A `start` pulse clears both accumulators, the sample counter, the reference phase and `done`, and opens a new block. A sample presented in the same cycle as `start` is not accumulated.
- R3: For the n-th accepted sample x(n) (n from 0), the reference phase is p(n) = n·`phase_step` mod 2^32. The real sum adds x(n)·S(p(n) + 2^30). The imaginary sum adds −x(n)·S(p(n)).
- R4: S(p) is found from the top 12 phase bits. Bits [31:30] give the quadrant q and bits [29:20] give the index i. For odd q, i is replaced by 1023−i. The table holds T(i) = round(2047·sin(π(2i+1)/4096)). S is T(i) when q < 2 and −T(i) when q ≥ 2.
- R5: A block accepts exactly 1024 samples. `done` is still 0 after the 1023rd accepted sample. It is 1 in the cycle after the 1024th accepted sample is presented.
- R6: A sample is ignored in two cases: when no block has been opened since reset, or after the 1024th sample. An ignored sample leaves `re_out` and `im_out` unchanged, and `done` stays 1 until the next `start`.
- R7: Each output is its accumulator shifted right arithmetically by SHIFT bits (default 17), then clamped to the range −32768 to 32767.
- R8: Cycles with `sample_valid` low neither add to the sums nor advance the phase or the count. The result of a block therefore does not depend on gaps between its samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a new block and clears all sums |
| sample_valid | input | 1 | Qualifies `sample` |
| sample | input | 12 | Signed ADC sample |
| phase_step | input | 32 | Reference phase increment per accepted sample |
| re_out | output | 16 | Scaled, saturated real result |
| im_out | output | 16 | Scaled, saturated imaginary result |
| done | output | 1 | High once a block of 1024 samples has been summed |

## Verification
A wrong phase, table entry or sign does not show up right away. It appears only in the final real or imaginary word, about 1024 accepted samples after `start`. To catch it, the bench compares complete blocks against exact sums built from a model of the table, using DC, a pure tone and random data. A wrong sample count makes `done` rise one cycle too early or too late, so `done` is checked at the 1023rd and the 1024th sample. A sample that leaks into the sums outside a block changes the outputs in the very next cycle. Clamping is checked on a second instance built with a smaller shift.

// File: rtl/dft_bin_correlator.sv
`timescale 1ns/1ps
module dft_bin_correlator #(
  parameter int SAMP_W   = 12,
  parameter int PHASE_W  = 32,
  parameter int N_LOG2   = 10,
  parameter int TAB_LOG2 = 10,
  parameter int AMP_W    = 12,
  parameter int ACC_W    = 36,
  parameter int OUT_W    = 16,
  parameter int SHIFT    = 17
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      sample_valid,
  input  logic signed [SAMP_W-1:0]  sample,
  input  logic [PHASE_W-1:0]        phase_step,
  output logic signed [OUT_W-1:0]   re_out,
  output logic signed [OUT_W-1:0]   im_out,
  output logic                      done
);
  localparam int TAB_N   = 1 << TAB_LOG2;
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;
  localparam int ADDR_W  = TAB_LOG2 + 2;
  localparam int PROD_W  = SAMP_W + AMP_W + 1;
  localparam logic signed [ACC_W-1:0] OUT_HI = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OUT_LO = ~OUT_HI;

  function automatic int sine_entry(input int k);
    real ang;
    ang = 3.141592653589793 * (2.0 * real'(k) + 1.0) / (4.0 * real'(TAB_N));
    return $rtoi(real'(AMP_MAX) * $sin(ang) + 0.5);
  endfunction

  logic [AMP_W-1:0] qtab [TAB_N];
  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    localparam int V = sine_entry(k);
    assign qtab[k] = AMP_W'(V);
  end

  function automatic logic [TAB_LOG2-1:0] fold(input logic [ADDR_W-1:0] a);
    return a[TAB_LOG2] ? ~a[TAB_LOG2-1:0] : a[TAB_LOG2-1:0];
  endfunction

  function automatic logic signed [OUT_W-1:0] scale(input logic signed [ACC_W-1:0] acc);
    logic signed [ACC_W-1:0] s;
    s = acc >>> SHIFT;
    if (s > OUT_HI) return {1'b0, {(OUT_W-1){1'b1}}};
    if (s < OUT_LO) return {1'b1, {(OUT_W-1){1'b0}}};
    return s[OUT_W-1:0];
  endfunction

  logic [PHASE_W-1:0]      phase;
  logic [N_LOG2-1:0]       cnt;
  logic                    active;
  logic signed [ACC_W-1:0] acc_re, acc_im;

  logic [ADDR_W-1:0]        a_sin, a_cos;
  logic signed [AMP_W:0]    m_sin, m_cos, v_sin, v_cos;
  logic signed [PROD_W-1:0] p_re, p_im;

  assign a_sin = phase[PHASE_W-1 -: ADDR_W];
  assign a_cos = a_sin + ADDR_W'(TAB_N);
  assign m_sin = $signed({1'b0, qtab[fold(a_sin)]});
  assign m_cos = $signed({1'b0, qtab[fold(a_cos)]});
  assign v_sin = a_sin[ADDR_W-1] ? -m_sin : m_sin;
  assign v_cos = a_cos[ADDR_W-1] ? -m_cos : m_cos;
  assign p_re  = PROD_W'(sample) * PROD_W'(v_cos);
  assign p_im  = PROD_W'(sample) * PROD_W'(v_sin);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0; cnt <= '0; active <= 1'b0; done <= 1'b0;
      acc_re <= '0; acc_im <= '0;
    end else if (start) begin
      phase <= '0; cnt <= '0; active <= 1'b1; done <= 1'b0;
      acc_re <= '0; acc_im <= '0;
    end else if (active && sample_valid) begin
      acc_re <= acc_re + ACC_W'(p_re);
      acc_im <= acc_im - ACC_W'(p_im);
      phase  <= phase + phase_step;
      cnt    <= cnt + 1'b1;
      if (&cnt) begin
        active <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assign re_out = scale(acc_re);
  assign im_out = scale(acc_im);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && acc_re == '0 && acc_im == '0 && cnt == '0));
  assert_done_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(&cnt) && $past(sample_valid) && $past(active)));
  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> ($stable(acc_re) && $stable(acc_im)));
  assert_gap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !start) |=> ($stable(phase) && $stable(cnt)));
  assert_closed_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
endmodule

// File: tb/dft_bin_correlator_bench.sv
`timescale 1ns/1ps
module dft_bin_correlator_bench;
  localparam int N = 1024;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, sample_valid;
  logic signed [11:0] sample;
  logic [31:0] phase_step;
  logic signed [15:0] re_out, im_out, re_sat, im_sat;
  logic done, done_sat;

  dft_bin_correlator u_dft_bin_correlator (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
    .sample(sample), .phase_step(phase_step),
    .re_out(re_out), .im_out(im_out), .done(done));

  dft_bin_correlator #(.SHIFT(12)) u_sat (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
    .sample(sample), .phase_step(phase_step),
    .re_out(re_sat), .im_out(im_sat), .done(done_sat));

  int tests = 0, fails = 0;
  int xs [N];

  function automatic int tab(input int i);
    return $rtoi(2047.0 * $sin(3.141592653589793 * (2.0 * i + 1.0) / 4096.0) + 0.5);
  endfunction

  function automatic int ref_sin(input bit [31:0] ph);
    int i;
    i = int'(ph[29:20]);
    if (ph[30]) i = 1023 - i;
    return ph[31] ? -tab(i) : tab(i);
  endfunction

  function automatic int fit(input longint acc, input int sh);
    longint s;
    s = acc >>> sh;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return int'(s);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_block(input string tag, input bit [31:0] step, input bit gaps, input int junk);
    longint re = 0, im = 0;
    bit [31:0] ph = 0;
    for (int n = 0; n < N; n++) begin
      re += longint'(xs[n]) * longint'(ref_sin(ph + 32'h4000_0000));
      im -= longint'(xs[n]) * longint'(ref_sin(ph));
      ph += step;
    end
    phase_step = step;
    @(negedge clk); start = 1'b1; sample_valid = 1'b1; sample = 12'sh7ff;
    @(negedge clk); start = 1'b0; sample_valid = 1'b0;
    if (junk > 0) begin
      for (int j = 0; j < junk; j++) begin
        sample_valid = 1'b1; sample = 12'sh3e8; @(negedge clk);
      end
      start = 1'b1; sample_valid = 1'b0;
      @(negedge clk); start = 1'b0;
      check({tag, " R2 restart clears done"}, int'(done), 0);
    end
    for (int n = 0; n < N; n++) begin
      if (gaps && (n % 3 == 1)) begin
        sample_valid = 1'b0; sample = -12'sd2048; @(negedge clk);
      end
      if (n == N - 1) check({tag, " R5 done low after 1023"}, int'(done), 0);
      sample_valid = 1'b1; sample = xs[n][11:0];
      @(negedge clk);
    end
    sample_valid = 1'b0;
    check({tag, " R5 done after 1024"}, int'(done), 1);
    check({tag, " R3 real"}, int'(re_out), fit(re, 17));
    check({tag, " R3 imag"}, int'(im_out), fit(im, 17));
    check({tag, " R7 real sat"}, int'(re_sat), fit(re, 12));
    check({tag, " R7 imag sat"}, int'(im_sat), fit(im, 12));
  endtask

  task automatic t_reset();
    check("R1 done", int'(done), 0);
    check("R1 real", int'(re_out), 0);
    check("R1 imag", int'(im_out), 0);
    for (int j = 0; j < 20; j++) begin
      @(negedge clk); sample_valid = 1'b1; sample = 12'sh5a5;
    end
    @(negedge clk); sample_valid = 1'b0;
    check("R6 no block real", int'(re_out), 0);
    check("R6 no block done", int'(done), 0);
  endtask

  task automatic t_dc_neg();
    for (int n = 0; n < N; n++) xs[n] = -2048;
    run_block("dc_neg R4", 32'h0, 1'b0, 0);
    check("R4 dc real value", int'(re_out), -32752);
  endtask

  task automatic t_dc_pos();
    for (int n = 0; n < N; n++) xs[n] = 2047;
    run_block("dc_pos", 32'h0, 1'b0, 0);
  endtask

  task automatic t_tone();
    for (int n = 0; n < N; n++) xs[n] = int'(2000.0 * $cos(2.0 * 3.141592653589793 * n / 64.0));
    run_block("tone R4", 32'h0400_0000, 1'b0, 0);
  endtask

  task automatic t_random_gaps();
    for (int n = 0; n < N; n++) xs[n] = int'($urandom_range(4095)) - 2048;
    run_block("rand R8", 32'h0357_9bdf, 1'b1, 0);
  endtask

  task automatic t_restart();
    for (int n = 0; n < N; n++) xs[n] = int'($urandom_range(4095)) - 2048;
    run_block("restart R2", 32'h1234_5679, 1'b0, 300);
  endtask

  task automatic t_ignore();
    int r, i;
    r = int'(re_out); i = int'(im_out);
    for (int j = 0; j < 40; j++) begin
      sample_valid = 1'b1; sample = 12'sh7ff; @(negedge clk);
    end
    sample_valid = 1'b0;
    check("R6 after done real", int'(re_out), r);
    check("R6 after done imag", int'(im_out), i);
    check("R6 done held", int'(done), 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check("R2 start clears done", int'(done), 0);
    check("R2 start clears real", int'(re_out), 0);
    check("R2 start clears imag", int'(im_out), 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(7));
    rst_n = 1'b0; start = 1'b0; sample_valid = 1'b0; sample = '0; phase_step = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dc_neg();
    t_dc_pos();
    t_tone();
    t_random_gaps();
    t_restart();
    t_ignore();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule